// File: doc/BRIEF.md
# Burst-Write Readback Self-Test Sequencer

This block runs on the host side of an SPI register link. It proves that the attached register slave accepts burst writes before any other configuration is sent. It does not shift bits itself. It drives an external SPI master one frame at a time through a small request interface: a start strobe, the target address, a length, a read/write select and outgoing data. It gets back a busy flag, a per-byte pull strobe for bursts, and the read data.

After a start pulse the sequencer runs a fixed order of frames:

- one write burst of ten known bytes into ten consecutive registers;
- ten single-byte reads of those registers in ascending order, each compared with the byte that was written;
- ten single-byte writes that return every tested register to zero. These run whatever the verdict was.

When the last zeroing write has finished, the block raises `done` with exactly one of `pass` or `fail`. It also reports the first failing address and the total number of bad readbacks. A readback of all-zeros or all-ones usually means no device answered or the data line is stuck. That case is flagged apart from an ordinary wrong byte.

Top module: `burst_selftest`

## Requirements
- R1: The first frame after an accepted start is a write with `spi_rnw`=0, `spi_addr`=0x0010 and `spi_len`=10. During it, `spi_wdata` carries 0x01, 0x02, … 0x0A in turn, moving to the next byte on each cycle in which `spi_wnext` is high.
- R2: Ten read frames follow (`spi_rnw`=1, `spi_len`=1) to addresses 0x0010 through 0x0019 in ascending order. The byte expected from address A is A−0x0010+1.
- R3: Ten write frames follow (`spi_rnw`=0, `spi_len`=1, `spi_wdata`=0x00) to addresses 0x0010 through 0x0019 in ascending order, whatever the comparison results. No further frame is issued after them.
- R4: `spi_start` is high for one cycle only and only while `spi_busy` is low. A new frame is issued only after the current one has shown `spi_busy` high and then low, so each run has exactly 21 frames.
- R5: `done` rises in the cycle after `spi_busy` falls at the end of the last zeroing write. It stays high until a start is accepted. While `done` is high, exactly one of `pass` and `fail` is high. Neither is high while `done` is low.
- R6: `pass` means every readback matched. `err_count` equals the number of mismatching readbacks. `fail_addr` holds the first mismatching address in read order, and the remaining reads still run after a mismatch.
- R7: A readback of 0x00 or 0xFF counts as a mismatch and sets `stuck_seen`. Any other wrong readback sets `mismatch_seen`.
- R8: A `start_i` pulse while a run is in progress has no effect on the frames or the results.
- R9: A synchronous active-high `rst` returns the block to idle, with `done`, `pass`, `fail`, both flags and `err_count` cleared and no frame issued.
- R10: A start accepted while `done` is high clears `done`, the verdict and the error record, and runs the whole sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a run (accepted when idle or done) |
| spi_start | output | 1 | One-cycle frame request to the SPI master |
| spi_rnw | output | 1 | Frame direction, 1 = read |
| spi_addr | output | 16 | Register address of the frame (first address of a burst) |
| spi_len | output | 4 | Number of data bytes in the frame |
| spi_wdata | output | 8 | Write byte currently offered to the master |
| spi_wnext | input | 1 | Master has taken the offered burst byte |
| spi_busy | input | 1 | Master is executing a frame |
| spi_rdata | input | 8 | Read byte, valid when busy falls after a read |
| done | output | 1 | Run complete, verdict valid |
| pass | output | 1 | All readbacks matched |
| fail | output | 1 | At least one readback mismatched |
| fail_addr | output | 16 | First mismatching address |
| err_count | output | 4 | Number of mismatching readbacks |
| stuck_seen | output | 1 | Some readback was 0x00 or 0xFF |
| mismatch_seen | output | 1 | Some readback was wrong but not 0x00/0xFF |

## Verification
The properties assume a well-behaved SPI master. It raises `spi_busy` in the cycle after it accepts `spi_start` and keeps it high for at least one cycle. It pulses `spi_wnext` only inside a burst and no more often than every other cycle. It presents `spi_rdata` no later than the cycle in which `busy` falls. The bench's master model keeps to these rules. It varies only the busy length of single-byte frames (zero to four extra cycles) and the read data it returns. With stuck values, single and double corruptions, and a start pulse in mid-run, it reaches every verdict path while staying inside that contract.

// File: rtl/bst_pkg.sv
package bst_pkg;

    parameter int BST_ADDR_W = 16;
    parameter int BST_DATA_W = 8;

    typedef logic [BST_ADDR_W-1:0] addr_t;
    typedef logic [BST_DATA_W-1:0] byte_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BURST,
        ST_BURST_W,
        ST_READ,
        ST_READ_W,
        ST_CHECK,
        ST_CLEAR,
        ST_CLEAR_W,
        ST_DONE
    } seq_state_t;

    // One comparison handed from the sequencer to the tally
    typedef struct packed {
        logic  valid;
        addr_t addr;
        byte_t got;
        byte_t want;
    } probe_t;

    // Known byte for slot n of the tested window
    function automatic byte_t pattern_byte(input int unsigned slot);
        return byte_t'(slot + 1);
    endfunction

    // All-zero or all-one readback: likely no response or a stuck line
    function automatic logic is_rail(input byte_t b);
        return (b == '0) || (b == '1);
    endfunction

endpackage

// File: rtl/bst_seq.sv
module bst_seq
    import bst_pkg::*;
#(
    parameter int    NUM_BYTES = 10,
    parameter addr_t BASE_ADDR = 16'h0010,
    localparam int   CNT_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             spi_busy,
    input  logic             spi_wnext,
    input  byte_t            spi_rdata,
    output logic             spi_start,
    output logic             spi_rnw,
    output addr_t            spi_addr,
    output logic [CNT_W-1:0] spi_len,
    output byte_t            spi_wdata,
    output logic             run_clr,
    output logic             finish,
    output logic             done,
    output probe_t           probe
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BYTES - 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(NUM_BYTES);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] idx_q, idx_d;
    logic             seen_q;
    byte_t            rd_q;
    logic             issue, waiting, wait_over, in_burst, idle_like;

    always_comb begin
        issue     = state_q inside {ST_BURST, ST_READ, ST_CLEAR};
        waiting   = state_q inside {ST_BURST_W, ST_READ_W, ST_CLEAR_W};
        in_burst  = state_q inside {ST_BURST, ST_BURST_W};
        idle_like = state_q inside {ST_IDLE, ST_DONE};
        wait_over = waiting && seen_q && !spi_busy;
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (start_i) begin
                    state_d = ST_BURST;
                    idx_d   = '0;
                end
            end
            ST_BURST: if (!spi_busy) state_d = ST_BURST_W;
            ST_BURST_W: begin
                if (spi_wnext && idx_q != LAST) idx_d = idx_q + 1'b1;
                if (wait_over) begin
                    state_d = ST_READ;
                    idx_d   = '0;
                end
            end
            ST_READ:   if (!spi_busy) state_d = ST_READ_W;
            ST_READ_W: if (wait_over) state_d = ST_CHECK;
            ST_CHECK: begin
                if (idx_q == LAST) begin
                    state_d = ST_CLEAR;
                    idx_d   = '0;
                end else begin
                    state_d = ST_READ;
                    idx_d   = idx_q + 1'b1;
                end
            end
            ST_CLEAR: if (!spi_busy) state_d = ST_CLEAR_W;
            ST_CLEAR_W: begin
                if (wait_over) begin
                    if (idx_q == LAST) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d = ST_CLEAR;
                        idx_d   = idx_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            seen_q  <= 1'b0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            if (issue) begin
                seen_q <= 1'b0;
            end else if (waiting && spi_busy) begin
                seen_q <= 1'b1;
            end
            if (state_q == ST_READ_W && wait_over) begin
                rd_q <= spi_rdata;
            end
        end
    end

    always_comb begin
        spi_start   = issue && !spi_busy;
        spi_rnw     = state_q inside {ST_READ, ST_READ_W};
        spi_addr    = in_burst ? BASE_ADDR : BASE_ADDR + addr_t'(idx_q);
        spi_len     = in_burst ? FULL : ONE;
        spi_wdata   = in_burst ? pattern_byte(int'(idx_q)) : '0;
        run_clr     = idle_like && start_i;
        finish      = (state_q == ST_CLEAR_W) && wait_over && (idx_q == LAST);
        done        = (state_q == ST_DONE);
        probe.valid = (state_q == ST_CHECK);
        probe.addr  = BASE_ADDR + addr_t'(idx_q);
        probe.got   = rd_q;
        probe.want  = pattern_byte(int'(idx_q));
    end

endmodule

// File: rtl/bst_tally.sv
module bst_tally
    import bst_pkg::*;
#(
    parameter int  NUM_BYTES = 10,
    localparam int CNT_W     = $clog2(NUM_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             finish,
    input  probe_t           probe,
    output logic             pass,
    output logic             fail,
    output addr_t            fail_addr,
    output logic [CNT_W-1:0] err_count,
    output logic             stuck_seen,
    output logic             mismatch_seen
);

    logic miss;

    always_comb miss = probe.valid && (probe.got != probe.want);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pass          <= 1'b0;
            fail          <= 1'b0;
            fail_addr     <= '0;
            err_count     <= '0;
            stuck_seen    <= 1'b0;
            mismatch_seen <= 1'b0;
        end else begin
            if (miss) begin
                err_count <= err_count + 1'b1;
                if (err_count == '0) fail_addr <= probe.addr;
                if (is_rail(probe.got)) begin
                    stuck_seen <= 1'b1;
                end else begin
                    mismatch_seen <= 1'b1;
                end
            end
            if (finish) begin
                pass <= (err_count == '0);
                fail <= (err_count != '0);
            end
        end
    end

endmodule

// File: rtl/burst_selftest.sv
module burst_selftest
    import bst_pkg::*;
#(
    parameter int    NUM_BYTES = 10,
    parameter addr_t BASE_ADDR = 16'h0010
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start_i,
    output logic                              spi_start,
    output logic                              spi_rnw,
    output logic [BST_ADDR_W-1:0]             spi_addr,
    output logic [$clog2(NUM_BYTES + 1)-1:0]  spi_len,
    output logic [BST_DATA_W-1:0]             spi_wdata,
    input  logic                              spi_wnext,
    input  logic                              spi_busy,
    input  logic [BST_DATA_W-1:0]             spi_rdata,
    output logic                              done,
    output logic                              pass,
    output logic                              fail,
    output logic [BST_ADDR_W-1:0]             fail_addr,
    output logic [$clog2(NUM_BYTES + 1)-1:0]  err_count,
    output logic                              stuck_seen,
    output logic                              mismatch_seen
);

    logic   run_clr;
    logic   finish;
    probe_t probe;

    bst_seq #(
        .NUM_BYTES (NUM_BYTES),
        .BASE_ADDR (BASE_ADDR)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .spi_busy  (spi_busy),
        .spi_wnext (spi_wnext),
        .spi_rdata (spi_rdata),
        .spi_start (spi_start),
        .spi_rnw   (spi_rnw),
        .spi_addr  (spi_addr),
        .spi_len   (spi_len),
        .spi_wdata (spi_wdata),
        .run_clr   (run_clr),
        .finish    (finish),
        .done      (done),
        .probe     (probe)
    );

    bst_tally #(
        .NUM_BYTES (NUM_BYTES)
    ) u_tally (
        .clk           (clk),
        .rst           (rst),
        .clr           (run_clr),
        .finish        (finish),
        .probe         (probe),
        .pass          (pass),
        .fail          (fail),
        .fail_addr     (fail_addr),
        .err_count     (err_count),
        .stuck_seen    (stuck_seen),
        .mismatch_seen (mismatch_seen)
    );

endmodule

// File: rtl/bst_sva.sv
module bst_sva
    import bst_pkg::*;
#(
    parameter int    NUM_BYTES = 10,
    parameter addr_t BASE_ADDR = 16'h0010,
    localparam int   CNT_W     = $clog2(NUM_BYTES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             spi_start,
    input logic             spi_rnw,
    input addr_t            spi_addr,
    input logic [CNT_W-1:0] spi_len,
    input logic             done,
    input logic             pass,
    input logic             fail,
    input logic [CNT_W-1:0] err_count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    AST_BURST_FRAME: assert property (@(posedge clk) disable iff (rst)
        (spi_start && spi_len != ONE) |-> (spi_addr == BASE_ADDR && !spi_rnw)); // R1

    AST_QUIET_DONE: assert property (@(posedge clk) disable iff (rst)
        done |-> !spi_start); // R3

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        spi_start |=> !spi_start); // R4

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start_i) |=> done); // R5

    AST_VERDICT_DONE: assert property (@(posedge clk) disable iff (rst)
        (pass || fail) |-> done); // R5

    AST_VERDICT_ONE: assert property (@(posedge clk) disable iff (rst)
        done |-> (pass ^ fail)); // R5

    AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (rst)
        pass |-> (err_count == '0)); // R6

    AST_FAIL_COUNTED: assert property (@(posedge clk) disable iff (rst)
        fail |-> (err_count != '0)); // R6

    AST_RESTART_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (done && start_i) |=> (!done && !pass && !fail)); // R10

endmodule

bind burst_selftest bst_sva #(
    .NUM_BYTES (NUM_BYTES),
    .BASE_ADDR (BASE_ADDR)
) u_sva (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .spi_start (spi_start),
    .spi_rnw   (spi_rnw),
    .spi_addr  (spi_addr),
    .spi_len   (spi_len),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .err_count (err_count)
);

// File: tb/burst_selftest_tb.sv
`timescale 1ns/1ps
module burst_selftest_tb;

    localparam int          NB   = 10;
    localparam int          LW   = $clog2(NB + 1);
    localparam logic [15:0] BASE = 16'h0010;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic          spi_start, spi_rnw;
    logic [15:0]   spi_addr;
    logic [LW-1:0] spi_len;
    logic [7:0]    spi_wdata;
    logic          spi_wnext, spi_busy;
    logic [7:0]    spi_rdata;
    logic          done, pass, fail;
    logic [15:0]   fail_addr;
    logic [LW-1:0] err_count;
    logic          stuck_seen, mismatch_seen;

    always #2.5 clk = ~clk;

    burst_selftest u_dut (
        .clk (clk), .rst (rst), .start_i (start_i),
        .spi_start (spi_start), .spi_rnw (spi_rnw), .spi_addr (spi_addr),
        .spi_len (spi_len), .spi_wdata (spi_wdata), .spi_wnext (spi_wnext),
        .spi_busy (spi_busy), .spi_rdata (spi_rdata),
        .done (done), .pass (pass), .fail (fail), .fail_addr (fail_addr),
        .err_count (err_count), .stuck_seen (stuck_seen), .mismatch_seen (mismatch_seen)
    );

    // ---------------- behavioural SPI master + register slave + reference ----------------
    logic [7:0]  mem [0:255];
    int          m_lat = 1;
    bit          flt_all = 0, flt_on1 = 0, flt_on2 = 0;
    logic [15:0] flt_a1 = 0, flt_a2 = 0;
    logic [7:0]  flt_v1 = 0, flt_v2 = 0;

    bit          m_running, m_burst, m_rnw, last_drop;
    logic [15:0] f_addr;
    int          f_left, f_k, f_cnt, m_frames;
    bit          exp_done, exp_pass, exp_fail, exp_stuck, exp_mis;
    int          exp_err;
    logic [15:0] exp_first;

    function automatic logic [7:0] resp(input logic [15:0] a);
        if (flt_all) return 8'hFF;
        if (flt_on1 && a == flt_a1) return flt_v1;
        if (flt_on2 && a == flt_a2) return flt_v2;
        return mem[a[7:0]];
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            spi_busy <= 0; spi_wnext <= 0; spi_rdata <= 0;
            m_running <= 0; m_frames <= 0; last_drop <= 0;
            exp_done <= 0; exp_pass <= 0; exp_fail <= 0;
            exp_err <= 0; exp_first <= 0; exp_stuck <= 0; exp_mis <= 0;
        end else begin
            last_drop <= 0;
            if (last_drop) begin
                exp_done  <= 1;
                exp_pass  <= (exp_err == 0);
                exp_fail  <= (exp_err != 0);
                m_running <= 0;
            end
            if (start_i && !m_running) begin
                m_running <= 1; m_frames <= 0;
                exp_done <= 0; exp_pass <= 0; exp_fail <= 0;
                exp_err <= 0; exp_first <= 0; exp_stuck <= 0; exp_mis <= 0;
            end
            if (!spi_busy) begin
                if (spi_start) begin
                    spi_busy <= 1;
                    f_addr   <= spi_addr;
                    m_rnw    <= spi_rnw;
                    m_burst  <= (spi_len != 1);
                    f_left   <= int'(spi_len);
                    f_k      <= 0;
                    f_cnt    <= m_lat;
                    m_frames <= m_frames + 1;
                    if (!spi_rnw && spi_len == 1) mem[spi_addr[7:0]] <= spi_wdata;
                end
            end else if (m_burst) begin
                if (spi_wnext) begin
                    spi_wnext <= 0;
                end else if (f_left != 0) begin
                    mem[8'(f_addr + 16'(f_k))] <= spi_wdata;
                    f_k       <= f_k + 1;
                    f_left    <= f_left - 1;
                    spi_wnext <= 1;
                end else begin
                    spi_busy <= 0;
                end
            end else if (f_cnt != 0) begin
                f_cnt <= f_cnt - 1;
            end else begin
                spi_busy <= 0;
                if (m_rnw) begin
                    spi_rdata <= resp(f_addr);
                    if (resp(f_addr) != 8'(f_addr - BASE + 16'd1)) begin
                        exp_err <= exp_err + 1;
                        if (exp_err == 0) exp_first <= f_addr;
                        if (resp(f_addr) == 8'h00 || resp(f_addr) == 8'hFF) exp_stuck <= 1;
                        else exp_mis <= 1;
                    end
                end
                if (m_frames == 2 * NB + 1) last_drop <= 1;
            end
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0;
    int n_err    = 0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic frame_check(input int i);
        if (i == 0) begin
            check(spi_addr == BASE && !spi_rnw && spi_len == LW'(NB),
                  "R1 burst frame", {spi_rnw, spi_len, spi_addr}, {1'b0, LW'(NB), BASE});
        end else if (i <= NB) begin
            check(spi_rnw && spi_len == 1 && spi_addr == BASE + 16'(i - 1),
                  "R2 read frame", {spi_rnw, spi_len, spi_addr}, {1'b1, LW'(1), BASE + 16'(i - 1)});
        end else if (i <= 2 * NB) begin
            check(!spi_rnw && spi_len == 1 && spi_wdata == 8'h00 && spi_addr == BASE + 16'(i - NB - 1),
                  "R3 clear frame", {spi_rnw, spi_wdata, spi_addr}, {1'b0, 8'h00, BASE + 16'(i - NB - 1)});
        end else begin
            check(0, "R4 extra frame", i, 2 * NB);
        end
    endtask

    task automatic cycle_checks();
        check(done === exp_done, "R5 done", done, exp_done);
        check(pass === exp_pass, "R6 pass", pass, exp_pass);
        check(fail === exp_fail, "R6 fail", fail, exp_fail);
        if (exp_done) begin
            check(err_count == LW'(exp_err), "R6 err_count", err_count, exp_err);
            if (exp_fail) check(fail_addr == exp_first, "R6 fail_addr", fail_addr, exp_first);
            check(stuck_seen == exp_stuck, "R7 stuck_seen", stuck_seen, exp_stuck);
            check(mismatch_seen == exp_mis, "R7 mismatch_seen", mismatch_seen, exp_mis);
        end
        if (spi_start) begin
            check(!spi_busy, "R4 start while busy", spi_busy, 0);
            if (!spi_busy) frame_check(m_frames);
        end
        if (spi_busy && m_burst && !spi_wnext && f_left != 0)
            check(spi_wdata == 8'(f_k + 1), "R1 burst byte", spi_wdata, f_k + 1);
    endtask

    // Starts a run at a negedge; optional mid-run start poke and early stop
    task automatic run_seq(input int lat, input int poke_at, input int cut_at);
        m_lat   = lat;
        start_i = 1;
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk);
            start_i = 0;
            cycle_checks();
            if (c == poke_at) start_i = 1;
            if (cut_at >= 0 && m_frames >= cut_at) return;
            if (exp_done && done && c != poke_at) return;
        end
        check(0, "R5 watchdog", 0, 1);
    endtask

    task automatic expect_result(input bit p, input int errs, input logic [15:0] fa,
                                 input bit st, input bit mi);
        check(done == 1, "R5 done at end", done, 1);
        check(pass == p, "R6 verdict pass", pass, p);
        check(fail == !p, "R6 verdict fail", fail, !p);
        check(err_count == LW'(errs), "R6 error total", err_count, errs);
        if (!p) check(fail_addr == fa, "R6 first failing address", fail_addr, fa);
        check(stuck_seen == st, "R7 stuck flag", stuck_seen, st);
        check(mismatch_seen == mi, "R7 mismatch flag", mismatch_seen, mi);
        for (int a = 0; a < NB; a++)
            check(mem[8'(BASE + 16'(a))] == 8'h00, "R3 location zeroed", mem[8'(BASE + 16'(a))], 0);
        check(m_frames == 2 * NB + 1, "R4 frame total", m_frames, 2 * NB + 1);
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'h5A;
        rst = 1;
        repeat (3) @(negedge clk);
        check(!done && !pass && !fail && !spi_start, "R9 reset state",
              {done, pass, fail, spi_start}, 0);
        rst = 0;
        @(negedge clk);
        cycle_checks();

        // Clean run: pass
        run_seq(1, -1, -1);
        expect_result(1, 0, 16'h0, 0, 0);

        // R10 restart from done; every readback all-ones
        flt_all = 1;
        run_seq(4, -1, -1);
        expect_result(0, NB, BASE, 1, 0);
        flt_all = 0;

        // One corrupted byte at 0x13
        flt_on1 = 1; flt_a1 = 16'h0013; flt_v1 = 8'h44;
        run_seq(2, -1, -1);
        expect_result(0, 1, 16'h0013, 0, 1);

        // Zero readback at 0x15 and wrong byte at 0x17, shortest busy
        flt_a1 = 16'h0015; flt_v1 = 8'h00;
        flt_on2 = 1; flt_a2 = 16'h0017; flt_v2 = 8'h33;
        run_seq(0, -1, -1);
        expect_result(0, 2, 16'h0015, 1, 1);
        flt_on1 = 0; flt_on2 = 0;

        // R8: start pulse during a run is ignored
        run_seq(1, 30, -1);
        expect_result(1, 0, 16'h0, 0, 0);

        // R9: reset in mid-run
        run_seq(1, -1, 6);
        rst = 1;
        @(negedge clk);
        check(!done && !pass && !fail && !spi_start && err_count == 0 && !stuck_seen && !mismatch_seen,
              "R9 reset mid-run", {done, pass, fail, spi_start, err_count}, 0);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(!spi_start && !done, "R9 idle after reset", {spi_start, done}, 0);
            cycle_checks();
        end

        // Recovery run after reset
        run_seq(3, -1, -1);
        expect_result(1, 0, 16'h0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule